// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Blanking Controls

This block turns one 4-bit binary-coded digit into seven active-low segment drives for a single display digit. It is purely combinational. Three control inputs shape the output. A forced blank turns every segment off. A lamp test lights every segment. A ripple-blank input suppresses a zero digit.

The forced-blank input and the ripple-blank output are two separate ports. Together they stand for what would be one shared wired-AND node. The block resolves that node internally: an external low on the blank input pulls the ripple-blank output low as well. Chaining `rb_out_n` of one decoder into `rb_in_n` of the next suppresses leading or trailing zeros across a row of digits.

Top module: `bcd7_decoder`

## Requirements
- R1: `seg_n` is active low (0 lights a segment), with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g. With all controls high, the lit segments are: digit 0 → a,b,c,d,e,f; 1 → b,c; 2 → a,b,d,e,g; 3 → a,b,c,d,g; 4 → b,c,f,g; 5 → a,c,d,f,g; 7 → a,b,c; 8 → all seven.
- R2: With all controls high, digit 6 lights c,d,e,f,g (no a), and digit 9 lights a,b,c,f,g (no d).
- R3: With all controls high, code 10 lights d,e,g; 11 lights c,d,g; 12 lights b,f,g; 13 lights a,d,f,g; 14 lights d,e,f,g.
- R4: With all controls high, code 15 lights no segment (`seg_n` = 7'h7F).
- R5: When `blank_in_n` is 0, `seg_n` is 7'h7F whatever the digit, `lamp_test_n` and `rb_in_n` are.
- R6: When `blank_in_n` is 0, `rb_out_n` is 0 (wired-AND of external blank and internal ripple output).
- R7: When `lamp_test_n` is 0 and `blank_in_n` is 1, `seg_n` is 7'h00 and `rb_out_n` is 1, for every digit and either `rb_in_n`.
- R8: When `rb_in_n` is 0, the digit is 0, and `lamp_test_n` and `blank_in_n` are 1, `seg_n` is 7'h7F and `rb_out_n` is 0.
- R9: Outside the conditions of R6 and R8, `rb_out_n` is 1.
- R10: A low `rb_in_n` has no effect on `seg_n` when the digit is non-zero; the segments match the normal decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit | input | 4 | BCD digit, 8421 weighting |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| rb_in_n | input | 1 | Active-low ripple-blank input, blanks a zero digit |
| blank_in_n | input | 1 | Active-low forced blank (external side of the wired-AND node) |
| rb_out_n | output | 1 | Active-low ripple-blank output (resolved wired-AND node) |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |

## Verification
The bench builds the block with its default parameters: a 4-bit digit and seven segments. These are the only widths the elaboration checks accept. With them, all sixteen input codes are reachable under each of the eight combinations of the three controls. The sweep therefore covers every priority interaction: forced blank over lamp test, lamp test over ripple blanking, and ripple blanking applied only to a zero digit. The zero-suppression tests drive the ripple input directly, as the neighbouring digit in a chain would.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
   localparam int unsigned DIGIT_W = 4;
   localparam int unsigned SEG_W   = 7;

   typedef logic [SEG_W-1:0]   seg_t;   // active-high lit mask, bit0 = a
   typedef logic [DIGIT_W-1:0] digit_t;

   typedef enum logic [1:0] {
      MODE_DECODE = 2'd0,
      MODE_RIPPLE = 2'd1,
      MODE_LAMP   = 2'd2,
      MODE_FORCE  = 2'd3
   } mode_t;

   // Lit-segment mask for one code, bit order {g,f,e,d,c,b,a}
   function automatic seg_t glyph_of(input digit_t code);
      seg_t m;
      case (code)
         4'd0:    m = 7'b011_1111;
         4'd1:    m = 7'b000_0110;
         4'd2:    m = 7'b101_1011;
         4'd3:    m = 7'b100_1111;
         4'd4:    m = 7'b110_0110;
         4'd5:    m = 7'b110_1101;
         4'd6:    m = 7'b111_1100;
         4'd7:    m = 7'b000_0111;
         4'd8:    m = 7'b111_1111;
         4'd9:    m = 7'b110_0111;
         4'd10:   m = 7'b101_1000;
         4'd11:   m = 7'b100_1100;
         4'd12:   m = 7'b110_0010;
         4'd13:   m = 7'b110_1001;
         4'd14:   m = 7'b111_1000;
         default: m = 7'b000_0000;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/bcd7_glyph.sv
module bcd7_glyph
   import bcd7_pkg::*;
#(
   parameter int unsigned CODE_W = DIGIT_W,
   parameter int unsigned OUT_W  = SEG_W
) (
   input  logic [CODE_W-1:0] code,
   output logic [OUT_W-1:0]  lit
);
   if (CODE_W != DIGIT_W) begin : g_bad_code_w
      $error("bcd7_glyph: CODE_W must equal %0d", DIGIT_W);
   end
   if (OUT_W != SEG_W) begin : g_bad_out_w
      $error("bcd7_glyph: OUT_W must equal %0d", SEG_W);
   end

   always_comb begin
      lit = glyph_of(code);
   end
endmodule

// File: rtl/bcd7_ctrl.sv
module bcd7_ctrl
   import bcd7_pkg::*;
#(
   parameter int unsigned CODE_W = DIGIT_W
) (
   input  logic [CODE_W-1:0] code,
   input  logic              lamp_test_n,
   input  logic              rb_in_n,
   input  logic              blank_in_n,
   output logic              node_n,
   output mode_t             mode
);
   localparam logic [CODE_W-1:0] ZERO = '0;

   logic zero_req;   // this digit asks to be suppressed
   always_comb begin
      zero_req = (code == ZERO) && !rb_in_n && lamp_test_n;
      // shared node: external driver and internal pull both may pull low
      node_n   = blank_in_n & ~zero_req;
      if (!node_n)
         mode = blank_in_n ? MODE_RIPPLE : MODE_FORCE;
      else if (!lamp_test_n)
         mode = MODE_LAMP;
      else
         mode = MODE_DECODE;
   end
endmodule

// File: rtl/bcd7_drive.sv
module bcd7_drive
   import bcd7_pkg::*;
#(
   parameter int unsigned OUT_W = SEG_W
) (
   input  mode_t            mode,
   input  logic [OUT_W-1:0] lit,
   output logic [OUT_W-1:0] seg_n
);
   for (genvar s = 0; s < OUT_W; s++) begin : g_seg
      always_comb begin
         case (mode)
            MODE_LAMP:   seg_n[s] = 1'b0;
            MODE_DECODE: seg_n[s] = ~lit[s];
            default:     seg_n[s] = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/bcd7_decoder.sv
module bcd7_decoder
   import bcd7_pkg::*;
#(
   parameter int unsigned CODE_W = DIGIT_W,
   parameter int unsigned OUT_W  = SEG_W
) (
   input  logic [CODE_W-1:0] digit,
   input  logic              lamp_test_n,
   input  logic              rb_in_n,
   input  logic              blank_in_n,
   output logic              rb_out_n,
   output logic [OUT_W-1:0]  seg_n
);
   mode_t            mode;
   logic [OUT_W-1:0] lit;

   bcd7_ctrl #(.CODE_W(CODE_W)) u_ctrl (
      .code        (digit),
      .lamp_test_n (lamp_test_n),
      .rb_in_n     (rb_in_n),
      .blank_in_n  (blank_in_n),
      .node_n      (rb_out_n),
      .mode        (mode)
   );

   bcd7_glyph #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_glyph (
      .code (digit),
      .lit  (lit)
   );

   bcd7_drive #(.OUT_W(OUT_W)) u_drive (
      .mode  (mode),
      .lit   (lit),
      .seg_n (seg_n)
   );
endmodule

// File: rtl/bcd7_decoder_chk.sv
module bcd7_decoder_chk #(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned OUT_W  = 7
) (
   input logic [CODE_W-1:0] digit,
   input logic              lamp_test_n,
   input logic              rb_in_n,
   input logic              blank_in_n,
   input logic              rb_out_n,
   input logic [OUT_W-1:0]  seg_n
);
   localparam logic [OUT_W-1:0] ALL_OFF = '1;
   localparam logic [OUT_W-1:0] ALL_ON  = '0;

   logic known;
   always_comb begin
      known = !$isunknown({digit, lamp_test_n, rb_in_n, blank_in_n});
      if (known) begin
         // R5
         p_force_blank_r5: assert (blank_in_n || seg_n == ALL_OFF)
            else $error("forced blank left a segment lit");
         // R6
         p_node_pulled_r6: assert (blank_in_n || !rb_out_n)
            else $error("blank input did not pull ripple output low");
         // R7
         p_lamp_test_r7: assert (!blank_in_n || lamp_test_n ||
                                 (seg_n == ALL_ON && rb_out_n))
            else $error("lamp test did not light all segments");
         // R8
         p_ripple_zero_r8: assert (!(blank_in_n && lamp_test_n && !rb_in_n &&
                                     digit == '0) ||
                                   (seg_n == ALL_OFF && !rb_out_n))
            else $error("zero not suppressed");
         // R9
         p_rbo_high_r9: assert (!blank_in_n || rb_in_n || !lamp_test_n ||
                                digit != '0 || !rb_out_n)
            else $error("ripple output state unexpected");
         p_rbo_idle_r9: assert (!(blank_in_n && (rb_in_n || !lamp_test_n ||
                                                 digit != '0)) || rb_out_n)
            else $error("ripple output low without cause");
      end
   end
endmodule

bind bcd7_decoder bcd7_decoder_chk #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_chk (
   .digit       (digit),
   .lamp_test_n (lamp_test_n),
   .rb_in_n     (rb_in_n),
   .blank_in_n  (blank_in_n),
   .rb_out_n    (rb_out_n),
   .seg_n       (seg_n)
);

// File: tb/bcd7_decoder_bench.sv
module bcd7_decoder_bench;
   logic       clk = 1'b0;
   logic [3:0] digit;
   logic       lamp_test_n, rb_in_n, blank_in_n;
   logic       rb_out_n;
   logic [6:0] seg_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   bcd7_decoder u_bcd7_decoder (
      .digit       (digit),
      .lamp_test_n (lamp_test_n),
      .rb_in_n     (rb_in_n),
      .blank_in_n  (blank_in_n),
      .rb_out_n    (rb_out_n),
      .seg_n       (seg_n)
   );

   // Expected lit masks from R1..R4, bit0 = a ... bit6 = g
   function automatic logic [6:0] ref_lit(input logic [3:0] c);
      logic [6:0] t [16];
      t[0]  = 7'h3F; t[1]  = 7'h06; t[2]  = 7'h5B; t[3]  = 7'h4F;
      t[4]  = 7'h66; t[5]  = 7'h6D; t[6]  = 7'h7C; t[7]  = 7'h07;
      t[8]  = 7'h7F; t[9]  = 7'h67; t[10] = 7'h58; t[11] = 7'h4C;
      t[12] = 7'h62; t[13] = 7'h69; t[14] = 7'h78; t[15] = 7'h00;
      return t[c];
   endfunction

   task automatic drive(input logic [3:0] d, input logic lt, input logic rbi,
                        input logic bi);
      @(negedge clk);
      digit = d; lamp_test_n = lt; rb_in_n = rbi; blank_in_n = bi;
      @(posedge clk);
      #5;
   endtask

   task automatic check7(input string req, input logic [6:0] act,
                         input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s digit=%0d lt=%b rbi=%b bi=%b seg_n act=%h exp=%h",
                  req, digit, lamp_test_n, rb_in_n, blank_in_n, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s digit=%0d lt=%b rbi=%b bi=%b rb_out_n act=%b exp=%b",
                  req, digit, lamp_test_n, rb_in_n, blank_in_n, act, exp);
      end
   endtask

   // Idle state: all controls inactive, digit 8
   task automatic t_idle;
      drive(4'd8, 1'b1, 1'b1, 1'b1);
      check7("R1", seg_n, 7'h00);
      check1("R9", rb_out_n, 1'b1);
   endtask

   task automatic t_decode_digits;
      for (int c = 0; c < 16; c++) begin
         drive(c[3:0], 1'b1, 1'b1, 1'b1);
         if (c == 6 || c == 9)      check7("R2", seg_n, ~ref_lit(c[3:0]));
         else if (c < 10)           check7("R1", seg_n, ~ref_lit(c[3:0]));
         else if (c < 15)           check7("R3", seg_n, ~ref_lit(c[3:0]));
         else                       check7("R4", seg_n, 7'h7F);
         check1("R9", rb_out_n, 1'b1);
      end
   endtask

   task automatic t_force_blank;
      for (int c = 0; c < 16; c++)
         for (int k = 0; k < 4; k++) begin
            drive(c[3:0], k[0], k[1], 1'b0);
            check7("R5", seg_n, 7'h7F);
            check1("R6", rb_out_n, 1'b0);
         end
   endtask

   task automatic t_lamp_test;
      for (int c = 0; c < 16; c++)
         for (int r = 0; r < 2; r++) begin
            drive(c[3:0], 1'b0, r[0], 1'b1);
            check7("R7", seg_n, 7'h00);
            check1("R7", rb_out_n, 1'b1);
         end
   endtask

   task automatic t_ripple;
      drive(4'd0, 1'b1, 1'b0, 1'b1);
      check7("R8", seg_n, 7'h7F);
      check1("R8", rb_out_n, 1'b0);
      for (int c = 1; c < 16; c++) begin
         drive(c[3:0], 1'b1, 1'b0, 1'b1);
         check7("R10", seg_n, ~ref_lit(c[3:0]));
         check1("R9", rb_out_n, 1'b1);
      end
      // zero shown normally when ripple input is high
      drive(4'd0, 1'b1, 1'b1, 1'b1);
      check7("R1", seg_n, 7'h40);
      check1("R9", rb_out_n, 1'b1);
   endtask

   // Two-digit leading-zero chain emulated through the ports
   task automatic t_chain;
      logic up_rbo;
      drive(4'd0, 1'b1, 1'b0, 1'b1);   // upper digit, grounded ripple input
      check7("R8", seg_n, 7'h7F);
      up_rbo = rb_out_n;
      drive(4'd0, 1'b1, up_rbo, 1'b1); // next digit also zero: suppressed
      check7("R8", seg_n, 7'h7F);
      drive(4'd5, 1'b1, 1'b0, 1'b1);   // upper digit non-zero
      up_rbo = rb_out_n;
      check1("R9", up_rbo, 1'b1);
      drive(4'd0, 1'b1, up_rbo, 1'b1); // inner zero kept visible
      check7("R1", seg_n, ~ref_lit(4'd0));
   endtask

   initial begin
      digit = '0; lamp_test_n = 1'b1; rb_in_n = 1'b1; blank_in_n = 1'b1;
      repeat (2) @(posedge clk);
      t_idle();
      t_decode_digits();
      t_force_blank();
      t_lamp_test();
      t_ripple();
      t_chain();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule